// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial bus sitting in front of a 512-byte internal memory. SCL and SDA are oversampled by the system clock. SDA is split into an input, a drive-enable and a drive value. The slave recognises its address byte, then takes in a word address and a data byte for a write, or sends stored bytes back for a read.

A STOP that ends a write with a data byte commits that byte and starts a fixed internal write time. During this time the slave does not react to START conditions, so a host can repeat an address byte until it is acknowledged again. An address pointer is kept between transfers. A read can use it directly (current address), or the host can first load it with a write that has no data and then issue a repeated START (random address). Either kind of read can return one byte or a run of bytes.

Top module: `ee2w_slave`

## Requirements
- R1: The address byte carries, from MSB to LSB, a 4-bit type field that must equal `DEV_TYPE` (default 1010), a bit that must equal `strap_a2`, a bit that must equal `strap_a1`, a block bit and the R/W bit (1 = read). On any mismatch the slave leaves SDA undriven, so the ninth clock reads high (no acknowledge).
- R2: The write sequence is: address byte with R/W=0, then word address, then one data byte, then STOP. Each of the three bytes is acknowledged, and the STOP stores the byte at location {block bit, word address}.
- R3: For `WR_CYCLES` system clocks after the STOP that commits a write, START conditions are ignored and a matching address byte is not acknowledged.
- R4: Once the internal write time has elapsed, the slave again acknowledges a matching address byte with R/W=0.
- R5: After a read or write of location n, the pointer holds n+1. A current-address read returns the byte at the pointer and then advances the pointer.
- R6: A random read is made of an address byte (R/W=0) and a word address with no data, followed by a repeated START and an address byte with R/W=1. It returns the byte at {block bit of the first address byte, word address}.
- R7: In a read, each master acknowledge after a byte makes the slave send the next location. The pointer wraps from 511 to 0.
- R8: After a byte the master does not acknowledge, the slave keeps SDA released (`sda_oe` low) until the next START.
- R9: Read data is shifted out MSB first. Each bit is set up while SCL is low and is held through the high phase.
- R10: In a write, the slave does not acknowledge any byte after the first data byte. Only the first data byte is stored, and it is still committed at STOP.
- R11: The block bit in an address byte with R/W=1 has no effect on the pointer, so a current read returns the pointer location.
- R12: Synchronous reset leaves `sda_oe` low and the pointer at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_o | output | 1 | Value the slave drives when enabled |
| sda_oe | output | 1 | High while the slave owns SDA |
| strap_a2 | input | 1 | Static strap compared with the upper select bit |
| strap_a1 | input | 1 | Static strap compared with the lower select bit |

## Verification
Bus pins pass through a two-flop synchroniser and an edge register, so the slave's SDA drive changes about three system clocks after an SCL fall. The bench therefore changes SDA and samples it only at quarter-period points of an SCL period that is 16 clocks long: acknowledge and data bits are read in the middle of the high phase, and releases are checked two quarters after a falling edge. The busy window begins at the detected STOP and lasts `WR_CYCLES` clocks. A poll made right after the STOP falls well inside this window, and the bench waits `WR_CYCLES` plus margin before it expects an acknowledge again.

// File: rtl/ee2w_pkg.sv
`timescale 1ns/1ps
package ee2w_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DACK,
    ST_WORD,
    ST_WACK,
    ST_DATA,
    ST_DTACK,
    ST_TX,
    ST_MACK
  } ee2w_st_e;
endpackage

// File: rtl/ee2w_linein.sv
`timescale 1ns/1ps
module ee2w_linein #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev,
  output logic sda_s
);
  logic [STAGES-1:0] scl_sh;
  logic [STAGES-1:0] sda_sh;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh[0] <= 1'b1;
      sda_sh[0] <= 1'b1;
    end else begin
      scl_sh[0] <= scl_i;
      sda_sh[0] <= sda_i;
    end
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sh[g] <= 1'b1;
          sda_sh[g] <= 1'b1;
        end else begin
          scl_sh[g] <= scl_sh[g-1];
          sda_sh[g] <= sda_sh[g-1];
        end
      end
    end
  endgenerate

  assign scl_s = scl_sh[STAGES-1];
  assign sda_s = sda_sh[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/ee2w_mem.sv
`timescale 1ns/1ps
module ee2w_mem #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[wa] <= wd;
    q <= arr[ra];
  end
endmodule

// File: rtl/ee2w_wtimer.sv
`timescale 1ns/1ps
module ee2w_wtimer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (start)      cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R3
  busy_entry_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  // R3
  busy_count_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !start) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/ee2w_slave.sv
`timescale 1ns/1ps
module ee2w_slave
  import ee2w_pkg::*;
#(
  parameter int         WR_CYCLES   = 5000,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic sda_oe,
  input  logic strap_a2,
  input  logic strap_a1
);
  localparam int ADDR_W = BYTE_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic scl_rise, scl_fall, start_ev, stop_ev, sda_s;
  logic busy, mem_we;
  logic [BYTE_W-1:0] mem_q;

  ee2w_st_e          st;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txsh;
  logic [BYTE_W-1:0] wr_data;
  logic [ADDR_W-1:0] ptr;
  logic              rw_q, bs_q, wr_pend, more_q;
  logic              dev_hit;

  ee2w_linein #(.STAGES(SYNC_STAGES)) line_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_s(sda_s)
  );

  ee2w_mem #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) mem_i (
    .clk(clk), .we(mem_we), .wa(ptr), .wd(wr_data), .ra(ptr), .q(mem_q)
  );

  ee2w_wtimer #(.CYCLES(WR_CYCLES)) tmr_i (
    .clk(clk), .rst(rst), .start(mem_we), .busy(busy)
  );

  assign mem_we  = stop_ev & wr_pend;
  assign dev_hit = (shreg[7:4] == DEV_TYPE) && (shreg[3] == strap_a2)
                   && (shreg[2] == strap_a1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      txsh    <= '0;
      wr_data <= '0;
      ptr     <= '0;
      rw_q    <= 1'b0;
      bs_q    <= 1'b0;
      wr_pend <= 1'b0;
      more_q  <= 1'b0;
      sda_o   <= 1'b1;
      sda_oe  <= 1'b0;
    end else if (start_ev) begin
      sda_oe  <= 1'b0;
      wr_pend <= 1'b0;
      bitcnt  <= '0;
      st      <= busy ? ST_IDLE : ST_DEV;
    end else if (stop_ev) begin
      sda_oe  <= 1'b0;
      wr_pend <= 1'b0;
      st      <= ST_IDLE;
      if (wr_pend) ptr <= ptr + 1'b1;
    end else begin
      case (st)
        ST_DEV, ST_WORD, ST_DATA: begin
          if (scl_rise) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == LAST_BIT) begin
            bitcnt <= '0;
            if (st == ST_DEV) begin
              if (dev_hit) begin
                sda_oe <= 1'b1;
                sda_o  <= 1'b0;
                rw_q   <= shreg[0];
                if (!shreg[0]) bs_q <= shreg[1];
                st     <= ST_DACK;
              end else begin
                st <= ST_IDLE;
              end
            end else if (st == ST_WORD) begin
              ptr    <= {bs_q, shreg};
              sda_oe <= 1'b1;
              sda_o  <= 1'b0;
              st     <= ST_WACK;
            end else begin
              if (!wr_pend) begin
                wr_data <= shreg;
                wr_pend <= 1'b1;
                sda_oe  <= 1'b1;
                sda_o   <= 1'b0;
                st      <= ST_DTACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
        end
        ST_DACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              sda_oe <= 1'b1;
              sda_o  <= mem_q[BYTE_W-1];
              txsh   <= {mem_q[BYTE_W-2:0], 1'b0};
              bitcnt <= CNT_W'(1);
              ptr    <= ptr + 1'b1;
              st     <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_WORD;
            end
          end
        end
        ST_WACK, ST_DTACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= ST_DATA;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              st     <= ST_MACK;
            end else begin
              sda_o  <= txsh[BYTE_W-1];
              txsh   <= {txsh[BYTE_W-2:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            more_q <= ~sda_s;
          end else if (scl_fall) begin
            if (more_q) begin
              sda_oe <= 1'b1;
              sda_o  <= mem_q[BYTE_W-1];
              txsh   <= {mem_q[BYTE_W-2:0], 1'b0};
              bitcnt <= CNT_W'(1);
              ptr    <= ptr + 1'b1;
              st     <= ST_TX;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  busy_idle_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (st == ST_IDLE));

  // R2
  commit_free_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !busy);

  // R1
  ack_type_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DACK) |-> (shreg[7:4] == DEV_TYPE && shreg[3] == strap_a2
                         && shreg[2] == strap_a1));

  // R8
  drive_slot_chk: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (st inside {ST_DACK, ST_WACK, ST_DTACK, ST_TX}));

  // R12
  reset_release_chk: assert property (@(posedge clk)
    $past(rst) |-> !sda_oe);
endmodule

// File: tb/ee2w_slave_tb_top.sv
`timescale 1ns/1ps
module ee2w_slave_tb_top;
  localparam int WR_CYC = 300;
  localparam int Q      = 4;
  localparam int LIMIT  = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic dut_o, dut_oe;
  logic bus_sda;
  logic a2 = 1'b1;
  logic a1 = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;

  logic [7:0] mem_m [512];
  logic       known [512];
  logic [8:0] ptr_m;

  always #4 clk = ~clk;

  assign bus_sda = m_sda & (dut_oe ? dut_o : 1'b1);

  ee2w_slave #(.WR_CYCLES(WR_CYC)) dut_i (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(bus_sda),
    .sda_o(dut_o), .sda_oe(dut_oe), .strap_a2(a2), .strap_a1(a1)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] devb(input logic bs, input logic rw);
    return {4'b1010, 1'b1, 1'b0, bs, rw};
  endfunction

  task automatic start_c();
    tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b0;
  endtask

  task automatic rstart_c();
    tick(Q); m_sda = 1'b1; tick(Q); m_scl = 1'b1;
    tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b0;
  endtask

  task automatic stop_c();
    tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b1;
    tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_sda = b[i]; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0;
    end
    tick(Q); m_sda = 1'b1; tick(Q); m_scl = 1'b1;
    tick(Q); ack = bus_sda; tick(Q); m_scl = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_sda = 1'b1; tick(Q); m_scl = 1'b1;
      tick(Q); d[i] = bus_sda; tick(Q); m_scl = 1'b0;
    end
    tick(Q); m_sda = give_ack ? 1'b0 : 1'b1; tick(Q); m_scl = 1'b1;
    tick(2*Q); m_scl = 1'b0;
    if (!give_ack) begin
      tick(2*Q);
      chk(dut_oe == 1'b0, "R8 release after nack", int'(dut_oe), 0);
    end
  endtask

  task automatic expect_data(input logic [7:0] got, input string req);
    if (known[ptr_m]) chk(got == mem_m[ptr_m], req, int'(got), int'(mem_m[ptr_m]));
    ptr_m = ptr_m + 9'd1;
  endtask

  task automatic do_write(input logic [8:0] a, input logic [7:0] d,
                          input logic extra, input logic wait_done);
    logic ack;
    start_c();
    send_byte(devb(a[8], 1'b0), ack); chk(ack == 1'b0, "R2 addr ack", int'(ack), 0);
    send_byte(a[7:0], ack);           chk(ack == 1'b0, "R2 word ack", int'(ack), 0);
    send_byte(d, ack);                chk(ack == 1'b0, "R2 data ack", int'(ack), 0);
    if (extra) begin
      send_byte(~d, ack);
      chk(ack == 1'b1, "R10 extra byte nack", int'(ack), 1);
    end
    stop_c();
    mem_m[a] = d; known[a] = 1'b1; ptr_m = a + 9'd1;
    if (wait_done) tick(WR_CYC + 40);
  endtask

  task automatic do_rand_read(input logic [8:0] a, input int n, input string req);
    logic ack;
    logic [7:0] d;
    start_c();
    send_byte(devb(a[8], 1'b0), ack); chk(ack == 1'b0, "R6 addr ack", int'(ack), 0);
    send_byte(a[7:0], ack);           chk(ack == 1'b0, "R6 word ack", int'(ack), 0);
    rstart_c();
    send_byte(devb(1'b0, 1'b1), ack); chk(ack == 1'b0, "R6 read addr ack", int'(ack), 0);
    ptr_m = a;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      expect_data(d, req);
    end
    stop_c();
  endtask

  task automatic do_cur_read(input logic bs, input int n, input string req);
    logic ack;
    logic [7:0] d;
    start_c();
    send_byte(devb(bs, 1'b1), ack); chk(ack == 1'b0, "R5 read addr ack", int'(ack), 0);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      expect_data(d, req);
    end
    stop_c();
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic ack;
    logic [8:0] ra;
    logic [7:0] rd;
    int mode;
    void'($urandom(32'd2024));
    for (int i = 0; i < 512; i++) known[i] = 1'b0;
    ptr_m = '0;
    tick(6);
    rst = 1'b0;
    tick(2);
    chk(dut_oe == 1'b0, "R12 reset release", int'(dut_oe), 0);

    // R1: wrong strap bit and wrong type field
    start_c();
    send_byte({4'b1010, 1'b0, 1'b0, 1'b0, 1'b0}, ack);
    chk(ack == 1'b1, "R1 strap mismatch nack", int'(ack), 1);
    stop_c();
    start_c();
    send_byte({4'b0110, 1'b1, 1'b0, 1'b0, 1'b0}, ack);
    chk(ack == 1'b1, "R1 type mismatch nack", int'(ack), 1);
    stop_c();

    // R3 / R4: poll during and after the internal write time
    do_write(9'h1FF, 8'hA5, 1'b0, 1'b0);
    start_c();
    send_byte(devb(1'b0, 1'b0), ack);
    chk(ack == 1'b1, "R3 busy poll nack", int'(ack), 1);
    stop_c();
    tick(WR_CYC + 40);
    start_c();
    send_byte(devb(1'b0, 1'b0), ack);
    chk(ack == 1'b0, "R4 ready poll ack", int'(ack), 0);
    stop_c();

    do_write(9'h000, 8'h3C, 1'b0, 1'b1);
    do_write(9'h001, 8'h81, 1'b0, 1'b1);
    do_write(9'h100, 8'h77, 1'b0, 1'b1);

    // R7 wrap, R9 bit order via 0xA5/0x81
    do_rand_read(9'h1FF, 3, "R7 R9 sequential wrap");
    // R6 single byte, then R5 current read continues at next location
    do_rand_read(9'h000, 1, "R6 random byte");
    // R11: block bit 1 in read address does not move pointer (expects loc 0x001)
    do_cur_read(1'b1, 1, "R11 R5 current read");
    do_rand_read(9'h100, 1, "R6 upper block");

    // R10: second data byte refused, first stored
    do_write(9'h010, 8'h11, 1'b1, 1'b1);
    do_rand_read(9'h010, 1, "R10 first byte kept");

    // R5: write then current read of following written location
    do_write(9'h021, 8'h6E, 1'b0, 1'b1);
    do_write(9'h020, 8'hD2, 1'b0, 1'b1);
    do_cur_read(1'b0, 1, "R5 current after write");

    for (int it = 0; it < 22; it++) begin
      ra = 9'($urandom % 512);
      rd = 8'($urandom % 256);
      do_write(ra, rd, 1'b0, 1'b1);
      mode = int'($urandom % 3);
      if (mode == 0)      do_rand_read(ra, 1, "R6 random");
      else if (mode == 1) do_rand_read(ra - 9'd1, 2 + int'($urandom % 3), "R7 random seq");
      else                do_rand_read(ra, 2, "R7 R5 random pair");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule